// File: doc/BRIEF.md
# Two-Bank Frame Transmit Buffer

This block holds outgoing Ethernet frames in memory that software fills over a simple 32-bit register and memory bus, then plays each frame out as a byte stream with valid, last and ready signals toward a MAC serializer. There are two frame banks that software can fill in alternation, so one frame can be loaded while the other is being sent. Each bank has its own length register and its own status word. The status word carries a hardware-cleared busy flag and a software-cleared active flag. A shared interrupt enable gates a one-cycle completion pulse.

A bank can also be started in address-program mode. In that mode the first six bytes of the bank are copied into the station address output and no frame leaves the block. The second bank is a build-time option. With it disabled, the upper half of the address space does nothing and reads as zero.

Top module: `txbuf_engine`

## Requirements
- R1: After reset every status word, length register and the interrupt enable read 0, txValid and irq are 0, and stationAddr is 0.
- R2: Bank 0 covers byte addresses 0x000 to 0x7FF and bank 1 covers 0x800 to 0xFFF. Within a bank the frame length sits at offset 0x7F4 (bits 15:0, upper bits read 0) and the status word at 0x7FC. The interrupt enable is bit 31 at 0x7F8, in bank 0 only. Status bits are busy = 0, program = 1, interrupt enable = 3, active = 31, and all other bits read 0. The interrupt enable bit and the active bit read back as written.
- R3: Writing the status word with bit 0 set starts the bank. Exactly the number of bytes in the length register is emitted. Bytes are taken little-endian from 32-bit words, lowest address first, and txLast marks the final byte. While txReady is 0, txData, txValid and txLast hold.
- R4: Busy reads 0 from the cycle after the last byte is accepted. Active stays 1 until software writes it to 0.
- R5: A start with bits 0 and 1 both set loads bank bytes 0..5 into stationAddr, with byte n at bits 8n+7:8n. Both bits then clear, and no byte is emitted.
- R6: irq is a one-cycle pulse, in the cycle after the last byte is accepted, when both the global enable and the bank's enable are set. There is no pulse if either enable is clear, and none after an address program.
- R7: When both banks are waiting, frames leave in the order the banks were started.
- R8: Writing the status word of a bank that is still busy leaves its busy and program bits unchanged and sends no extra frame.
- R9: With the second bank disabled at build time, writes to bank 1 have no effect and its registers read 0.
- R10: A start with length 0 emits no byte, clears busy and still gives the completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe for one 32-bit word |
| busAddr | input | 12 | Byte address, word aligned |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| txData | output | 8 | Frame byte |
| txValid | output | 1 | txData is valid |
| txLast | output | 1 | Final byte of the frame |
| txReady | input | 1 | Serializer accepts the byte |
| stationAddr | output | 48 | Programmed station address |
| irq | output | 1 | Transmit completion pulse |

## Verification
A wrong byte counter or word index shows up on the first affected byte as a data or last-flag mismatch in the stream. A stuck busy bit shows up as a bank that never reads idle and a frame that is never served, while a busy bit that clears too early lets a second frame overtake the first. A lost active bit or a wrong program-mode decode is visible on the next status read, or in stationAddr on the following cycle. Stalling txReady in a pattern, and queueing both banks while the stream is stalled, brings ordering and hold faults out within one frame.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;
  localparam int LEN_W = 16;

  // command strobes from the control to the datapath
  typedef struct packed {
    logic             start;
    logic             prog;
    logic             bank;
    logic [LEN_W-1:0] len;
  } txCmd_t;
endpackage

// File: rtl/txbuf_ctrl.sv
module txbuf_ctrl
  import txbuf_pkg::*;
#(
  parameter bit DUAL_BANK = 1'b1,
  parameter int ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       wrData,
  input  logic              done,
  output txCmd_t            cmd,
  output logic [31:0]       rdData,
  output logic              irq
);
  localparam int WORD_W = ADDR_W - 3;
  localparam int WORDS  = 2 ** WORD_W;
  localparam logic [WORD_W-1:0] LEN_WORD  = WORD_W'(WORDS - 3);
  localparam logic [WORD_W-1:0] GIE_WORD  = WORD_W'(WORDS - 2);
  localparam logic [WORD_W-1:0] STAT_WORD = WORD_W'(WORDS - 1);

  logic              addrBank, bankOk, gieWr;
  logic [WORD_W-1:0] addrWord;
  logic [1:0]        busy, prog, ie, active, statusWr, lenWr, pend, clear;
  logic [LEN_W-1:0]  lenReg [2];
  logic              gie, running, curBank, selBank, startNow, immediate;

  assign addrBank = busAddr[ADDR_W-1];
  assign addrWord = busAddr[ADDR_W-2:2];
  assign bankOk   = DUAL_BANK || !addrBank;
  assign gieWr    = wrEn && !addrBank && addrWord == GIE_WORD;

  for (genvar b = 0; b < 2; b++) begin : g_dec
    assign statusWr[b] = wrEn && bankOk && addrBank == 1'(b) && addrWord == STAT_WORD;
    assign lenWr[b]    = wrEn && bankOk && addrBank == 1'(b) && addrWord == LEN_WORD;
    assign pend[b]     = busy[b] && !(running && curBank == 1'(b));
    assign clear[b]    = (done && curBank == 1'(b)) ||
                         (startNow && immediate && selBank == 1'(b));
  end

  // banks are picked up as soon as the engine is free, so start order is kept
  assign startNow  = !running && (pend != 2'b00);
  assign selBank   = !pend[0];
  assign immediate = prog[selBank] || lenReg[selBank] == '0;

  assign cmd.start = startNow;
  assign cmd.prog  = prog[selBank];
  assign cmd.bank  = selBank;
  assign cmd.len   = lenReg[selBank];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= '0; prog <= '0; ie <= '0; active <= '0;
      lenReg[0] <= '0; lenReg[1] <= '0;
      gie <= 1'b0; running <= 1'b0; curBank <= 1'b0; irq <= 1'b0;
    end else begin
      irq <= gie && ((done && ie[curBank]) ||
                     (startNow && immediate && !prog[selBank] && ie[selBank]));
      if (gieWr) gie <= wrData[31];
      if (done) running <= 1'b0;
      if (startNow && !immediate) begin
        running <= 1'b1;
        curBank <= selBank;
      end
      for (int b = 0; b < 2; b++) begin
        if (lenWr[b]) lenReg[b] <= wrData[LEN_W-1:0];
        if (statusWr[b]) begin
          ie[b]     <= wrData[3];
          active[b] <= wrData[31];
          if (!busy[b]) begin
            busy[b] <= wrData[0];
            prog[b] <= wrData[0] && wrData[1];
          end
        end
        if (clear[b]) begin
          busy[b] <= 1'b0;
          prog[b] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (bankOk) begin
      case (addrWord)
        LEN_WORD:  rdData[LEN_W-1:0] = lenReg[addrBank];
        GIE_WORD:  rdData[31] = gie && !addrBank;
        STAT_WORD: rdData = {active[addrBank], 27'b0, ie[addrBank], 1'b0,
                             prog[addrBank], busy[addrBank]};
        default:   rdData = '0;
      endcase
    end
  end

  // R6: a pulse is only produced when the global enable was on
  p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(gie));

  for (genvar b = 0; b < 2; b++) begin : g_chk
    // R4: hardware never drops active
    p_active_sw_only_r4: assert property (@(posedge clk) disable iff (!rstN)
      $fell(active[b]) |-> $past(statusWr[b]));
    // R3: busy is only raised by a status write
    p_busy_by_write_r3: assert property (@(posedge clk) disable iff (!rstN)
      $rose(busy[b]) |-> $past(statusWr[b]));
    // R8: a write to a busy bank cannot clear busy
    p_busy_kept_r8: assert property (@(posedge clk) disable iff (!rstN)
      (busy[b] && statusWr[b] && !clear[b]) |=> busy[b] && $stable(prog[b]));
  end
endmodule

// File: rtl/txbuf_datapath.sv
module txbuf_datapath
  import txbuf_pkg::*;
#(
  parameter bit DUAL_BANK = 1'b1,
  parameter int ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       wrData,
  input  txCmd_t            cmd,
  input  logic              txReady,
  output logic [7:0]        txData,
  output logic              txValid,
  output logic              txLast,
  output logic              done,
  output logic [47:0]       stationAddr
);
  localparam int NUM_BANKS = DUAL_BANK ? 2 : 1;
  localparam int WORD_W    = ADDR_W - 3;
  localparam int WORDS     = 2 ** WORD_W;

  logic [31:0]      rdWord [2];
  logic [31:0]      word0  [2];
  logic [31:0]      word1  [2];
  logic             sending, bank;
  logic [LEN_W-1:0] idx, len;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    if (b < NUM_BANKS) begin : g_mem
      logic [31:0] words [WORDS];
      always_ff @(posedge clk)
        if (wrEn && busAddr[ADDR_W-1] == 1'(b))
          words[busAddr[ADDR_W-2:2]] <= wrData;
      assign rdWord[b] = words[idx[WORD_W+1:2]];
      assign word0[b]  = words[0];
      assign word1[b]  = words[1];
    end else begin : g_none
      assign rdWord[b] = '0;
      assign word0[b]  = '0;
      assign word1[b]  = '0;
    end
  end

  assign txValid = sending;
  assign txLast  = sending && idx == len - 1'b1;
  assign txData  = rdWord[bank][8*idx[1:0] +: 8];
  assign done    = txLast && txReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sending <= 1'b0; bank <= 1'b0; idx <= '0; len <= '0;
      stationAddr <= '0;
    end else if (cmd.start) begin
      if (cmd.prog)
        stationAddr <= {word1[cmd.bank][15:0], word0[cmd.bank]};
      else if (cmd.len != '0) begin
        sending <= 1'b1;
        idx     <= '0;
        len     <= cmd.len;
        bank    <= cmd.bank;
      end
    end else if (sending && txReady) begin
      if (txLast) sending <= 1'b0;
      else        idx <= idx + 1'b1;
    end
  end

  // R3: a stalled byte is held unchanged
  p_hold_stall_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> txValid && $stable(txData) && $stable(txLast));
  // R5: the station address only moves on a program command
  p_station_prog_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(stationAddr) |-> $past(cmd.start && cmd.prog));
endmodule

// File: rtl/txbuf_engine.sv
module txbuf_engine
  import txbuf_pkg::*;
#(
  parameter bit DUAL_BANK = 1'b1,
  parameter int ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic [7:0]        txData,
  output logic              txValid,
  output logic              txLast,
  input  logic              txReady,
  output logic [47:0]       stationAddr,
  output logic              irq
);
  txCmd_t cmd;
  logic   done;

  txbuf_ctrl #(.DUAL_BANK(DUAL_BANK), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(busWrEn), .busAddr(busAddr),
    .wrData(busWrData), .done(done), .cmd(cmd), .rdData(busRdData), .irq(irq));

  txbuf_datapath #(.DUAL_BANK(DUAL_BANK), .ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .wrEn(busWrEn), .busAddr(busAddr),
    .wrData(busWrData), .cmd(cmd), .txReady(txReady), .txData(txData),
    .txValid(txValid), .txLast(txLast), .done(done), .stationAddr(stationAddr));
endmodule

// File: tb/txbuf_engine_test.sv
module txbuf_engine_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rstN = 1'b0, busWrEn = 1'b0, txReady = 1'b1;
  logic [11:0] busAddr = '0;
  logic [31:0] busWrData = '0, rdDual, rdSingle;
  logic [7:0]  txData, txDataS;
  logic        txValid, txLast, irq, txValidS, txLastS, irqS;
  logic [47:0] stationAddr, stationAddrS;

  int checks = 0, errors = 0, irqCount = 0, readyMode = 0, cyc = 0;
  bit finished = 0;
  logic [8:0] expQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  txbuf_engine #(.DUAL_BANK(1'b1)) uut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(rdDual), .txData(txData),
    .txValid(txValid), .txLast(txLast), .txReady(txReady),
    .stationAddr(stationAddr), .irq(irq));

  txbuf_engine #(.DUAL_BANK(1'b0)) uutSingle (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(rdSingle), .txData(txDataS),
    .txValid(txValidS), .txLast(txLastS), .txReady(txReady),
    .stationAddr(stationAddrS), .irq(irqS));

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ready pattern driver
  initial forever begin
    @(posedge clk);
    #1;
    cyc++;
    txReady = (readyMode == 0) ? 1'b1 : (readyMode == 1) ? (cyc % 3 != 0) : 1'b0;
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (irq) irqCount++;
    if (txValid && txReady) begin
      if (expQ.size() == 0)
        check(0, "R3 unexpected byte", {txLast, txData}, 0);
      else begin
        logic [8:0] e;
        e = expQ.pop_front();
        check({txLast, txData} == e, "R3 stream byte", {txLast, txData}, e);
      end
    end
  end

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d,
                         output logic [31:0] ds);
    @(negedge clk);
    busAddr = a;
    #1;
    d = rdDual; ds = rdSingle;
  endtask

  // driver: fill a bank, set its length, queue the expected bytes
  task automatic loadFrame(input bit bank, input int n, input logic [7:0] base);
    logic [11:0] off;
    off = bank ? 12'h800 : 12'h000;
    for (int w = 0; w < (n + 3) / 4; w++) begin
      logic [31:0] word;
      for (int k = 0; k < 4; k++) word[8*k +: 8] = base + 8'(4*w + k);
      busWrite(off + 12'(4*w), word);
    end
    for (int i = 0; i < n; i++) expQ.push_back({i == n - 1, base + 8'(i)});
    busWrite(off + 12'h7F4, 32'(n));
  endtask

  task automatic waitIdle(input bit bank, input string req);
    logic [31:0] s, ss;
    int t = 0;
    do begin
      busRead((bank ? 12'h800 : 12'h000) + 12'h7FC, s, ss);
      t++;
    end while (s[0] && t < 3000);
    check(!s[0], req, s, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, rs;
    int irqBefore;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRead(12'h7FC, r, rs);
    check(r == 0, "R1 status bank0", r, 0);
    busRead(12'hFFC, r, rs);
    check(r == 0, "R1 status bank1", r, 0);
    busRead(12'h7F4, r, rs);
    check(r == 0, "R1 length bank0", r, 0);
    check(!txValid && !irq, "R1 txValid irq", {txValid, irq}, 0);
    check(stationAddr == 0, "R1 stationAddr", stationAddr, 0);

    // R2 register map and readback
    busWrite(12'h7F4, 32'h1234ABCD);
    busRead(12'h7F4, r, rs);
    check(r == 32'h0000ABCD, "R2 length 16 bits", r, 32'h0000ABCD);
    busWrite(12'h7FC, 32'h80000008);
    busRead(12'h7FC, r, rs);
    check(r == 32'h80000008, "R2 status ie active", r, 32'h80000008);
    busWrite(12'h7F8, 32'h80000000);
    busRead(12'h7F8, r, rs);
    check(r == 32'h80000000, "R2 global enable", r, 32'h80000000);

    // R3 R4 R6 frame on bank 0, ready always high, both enables on
    loadFrame(0, 7, 8'h10);
    busWrite(12'h7FC, 32'h80000009);
    waitIdle(0, "R4 busy clears bank0");
    check(expQ.size() == 0, "R3 all bytes bank0", expQ.size(), 0);
    busRead(12'h7FC, r, rs);
    check(r == 32'h80000008, "R4 active kept", r, 32'h80000008);
    check(irqCount == 1, "R6 irq on completion", irqCount, 1);
    busWrite(12'h7FC, 32'h00000008);
    busRead(12'h7FC, r, rs);
    check(r == 32'h00000008, "R4 active cleared by write", r, 8);

    // R3 R6 bank 1 with stalls, bank enable off
    readyMode = 1;
    loadFrame(1, 10, 8'hA0);
    busWrite(12'hFFC, 32'h80000001);
    waitIdle(1, "R4 busy clears bank1");
    check(expQ.size() == 0, "R3 all bytes stalled", expQ.size(), 0);
    check(irqCount == 1, "R6 no irq with bank enable off", irqCount, 1);

    // R7 R8 R9 ordering with the stream stalled
    readyMode = 2;
    loadFrame(1, 5, 8'h40);
    loadFrame(0, 6, 8'h60);
    busWrite(12'hFFC, 32'h80000001);
    busWrite(12'h7FC, 32'h80000001);
    busWrite(12'hFFC, 32'h80000003);
    busRead(12'hFFC, r, rs);
    check(r == 32'h80000001, "R8 restart on busy bank ignored", r, 32'h80000001);
    check(rs == 0, "R9 single bank1 status", rs, 0);
    busRead(12'hFF4, r, rs);
    check(rs == 0, "R9 single bank1 length", rs, 0);
    check(r == 5, "R2 bank1 length", r, 5);
    readyMode = 1;
    waitIdle(1, "R7 bank1 served");
    waitIdle(0, "R7 bank0 served");
    check(expQ.size() == 0, "R7 order and count", expQ.size(), 0);
    repeat (5) @(negedge clk);
    check(!txValid, "R8 no extra frame", txValid, 0);

    // R5 address program with enables on: no bytes, no irq
    readyMode = 0;
    busWrite(12'h000, 32'h44332211);
    busWrite(12'h004, 32'hEEEE6655);
    irqBefore = irqCount;
    busWrite(12'h7FC, 32'h0000000B);
    waitIdle(0, "R5 busy clears after program");
    busRead(12'h7FC, r, rs);
    check(r == 32'h00000008, "R5 busy and program cleared", r, 8);
    check(stationAddr == 48'h665544332211, "R5 station address", stationAddr,
          48'h665544332211);
    check(irqCount == irqBefore, "R6 no irq for program", irqCount, irqBefore);
    check(stationAddrS == 48'h665544332211, "R9 single bank0 still works",
          stationAddrS, 48'h665544332211);

    // R10 zero length, then R6 with global enable off
    busWrite(12'h7F4, 32'h0);
    busWrite(12'h7FC, 32'h00000009);
    waitIdle(0, "R10 busy clears on zero length");
    check(irqCount == irqBefore + 1, "R10 irq on zero length", irqCount, irqBefore + 1);
    busWrite(12'h7F8, 32'h0);
    busWrite(12'h7FC, 32'h00000009);
    waitIdle(0, "R10 second zero length");
    check(irqCount == irqBefore + 1, "R6 no irq with global off", irqCount,
          irqBefore + 1);
    check(expQ.size() == 0 && !txValid, "R10 no bytes", expQ.size(), 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule